// File: doc/BRIEF.md
# Serial HD video descrambler and word aligner

This block sits behind a serial receiver that has already recovered the bit clock and turned the line rate into a 20-bit parallel bus, one bus word per pixel clock. The bits on that bus are still NRZI coded and scrambled, and they do not line up with the 10-bit video words. The block decodes the NRZI coding and removes the self-synchronising scrambler. It then slides a search window over the decoded bits until it finds a timing reference preamble. From that point it delivers bus words that start on a true 10-bit word boundary: the later word of each pair is luma, the earlier is chroma.

Each stage has its own bypass. With descrambling bypassed, the incoming bits are taken as plain data. With framing bypassed, the bits go out at the bus position where they arrived. By default the aligner jumps to the position of every preamble it sees. Its noise-immune mode makes it wait until two preambles in a row agree on a new position, so a single corrupted bit pattern cannot pull the boundary away.

Top module: `hdv_descram_framer`

## Requirements
- R1: While reset is asserted, `word_out` is all zeros and the boundary offset is zero. Reset is asynchronous active low and its release is synchronised to `clk`.
- R2: With neither bypass set, the input is decoded bit by bit as plain[i] = s[i] ^ s[i-4] ^ s[i-9], where s[i] = in[i] ^ in[i-1]. Bit 0 of each bus word is the earliest bit in time, and all history registers start at zero after reset. A word sampled at one rising edge appears on `word_out` after the fifth rising edge that samples it, shifted by the active boundary offset.
- R3: When `skip_descramble` is high, the input bits are treated as already plain, with no NRZI decode and no descrambling. The framer still works normally.
- R4: When `skip_framing` is high, `word_out` is the input word delayed by the pipeline at offset 0, and preambles have no effect on it. This holds whether or not descrambling is bypassed.
- R5: A preamble is 20 one bits followed at once by 40 zero bits in the decoded stream. This is the pattern that 3FF, 3FF, 000, 000, 000, 000 produces when chroma and luma are interleaved. The bit offset k (0 to 19) at which the ones start becomes the boundary, and each output word then begins at stream bit 20t+k.
- R6: In normal mode (`noise_immune` low), every preamble at a new offset moves the boundary. The first output word taken at the new boundary is the all-ones preamble word 0xFFFFF.
- R7: Between preambles the boundary does not move, even if the stream has slipped.
- R8: In noise-immune mode, a first preamble at a new offset leaves the boundary unchanged.
- R9: In noise-immune mode, a second preamble in a row at that same new offset moves the boundary. The preamble word itself is the first word delivered at the new boundary.
- R10: In noise-immune mode, a preamble at the current offset between two preambles at a new offset breaks the sequence, so the later one counts as a first sighting again.
- R11: Within an aligned output word, bits 9:0 hold the earlier 10-bit word in time (chroma) and bits 19:10 the later one (luma).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 20 | Coded, unaligned serial bits, bit 0 earliest |
| skip_descramble | input | 1 | High: take the input as plain bits |
| skip_framing | input | 1 | High: hold the boundary at offset 0 on the output |
| noise_immune | input | 1 | High: require two agreeing preambles before moving |
| word_out | output | 20 | Aligned word, luma 19:10, chroma 9:0 |

## Verification
A wrong bit in the descrambler history corrupts `word_out` for no more than nine bit times, so a decode fault shows up within one or two words after the five-cycle pipeline. A boundary register that moves too early or too late keeps every following word shifted until the next preamble. The bench therefore predicts the expected offset for every cycle and compares whole words, including cycles where the stream has slipped but no preamble has arrived yet. A candidate register in noise-immune mode that fails to clear shows up as a boundary that moves one preamble too soon.

// File: rtl/hdv_pkg.sv
package hdv_pkg;
  // width of one video sample and number of interleaved samples per bus word
  localparam int SYM_W = 10;
  localparam int LANES = 2;
  // self-synchronising scrambler taps (x^9 + x^4 + 1)
  localparam int SCR_TAP_LO = 4;
  localparam int SCR_TAP_HI = 9;
  // preamble shape in bus words: all-ones words, then all-zero words
  localparam int PRE_ONES_WORDS = 1;
  localparam int PRE_ZERO_WORDS = 2;

  typedef enum logic {
    CAND_NONE = 1'b0,
    CAND_HELD = 1'b1
  } cand_state_e;
endpackage

// File: rtl/hdv_bit_descrambler.sv
module hdv_bit_descrambler #(
  parameter int BUS_W  = 20,
  parameter int TAP_LO = 4,
  parameter int TAP_HI = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout
);
  localparam int EXT_W = BUS_W + TAP_HI;

  logic              nrzi_q, nrzi_n;
  logic [TAP_HI-1:0] hist_q, hist_n;
  logic [BUS_W-1:0]  dout_q, dout_n;
  logic [BUS_W-1:0]  chan;
  logic [EXT_W-1:0]  ext;

  // next state: NRZI decode, then the self-synchronising descramble
  always_comb begin
    chan = din ^ {din[BUS_W-2:0], nrzi_q};
    ext  = {chan, hist_q};
    for (int i = 0; i < BUS_W; i++) begin
      dout_n[i] = ext[i+TAP_HI] ^ ext[i+TAP_HI-TAP_LO] ^ ext[i];
    end
    if (bypass) begin
      dout_n = din;
    end
    nrzi_n = din[BUS_W-1];
    hist_n = ext[EXT_W-1 -: TAP_HI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q <= 1'b0;
      hist_q <= '0;
      dout_q <= '0;
    end else begin
      nrzi_q <= nrzi_n;
      hist_q <= hist_n;
      dout_q <= dout_n;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/hdv_preamble_finder.sv
module hdv_preamble_finder #(
  parameter int BUS_W  = 20,
  parameter int ONES_W = 20,
  parameter int ZERO_W = 40,
  parameter int WIN_W  = 80,
  parameter int OFF_W  = 5
) (
  input  logic [WIN_W-1:0] window,
  output logic             hit,
  output logic [OFF_W-1:0] hit_pos
);
  logic [BUS_W-1:0] match;

  // one comparator per candidate bit offset
  for (genvar k = 0; k < BUS_W; k++) begin : g_off
    assign match[k] = (&window[k +: ONES_W]) & ~(|window[k+ONES_W +: ZERO_W]);
  end

  // lowest matching offset wins
  always_comb begin
    hit_pos = '0;
    for (int k = BUS_W - 1; k >= 0; k--) begin
      if (match[k]) hit_pos = OFF_W'(k);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/hdv_boundary_ctrl.sv
module hdv_boundary_ctrl
  import hdv_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_pos,
  input  logic             noise_immune,
  input  logic             bypass,
  output logic [OFF_W-1:0] off_use,
  output logic [OFF_W-1:0] bound,
  output logic             cand_held
);
  logic [OFF_W-1:0] off_q, off_n;
  logic [OFF_W-1:0] cand_q, cand_n;
  cand_state_e      cst_q, cst_n;
  logic             take;

  always_comb begin
    off_n  = off_q;
    cand_n = cand_q;
    cst_n  = cst_q;
    take   = 1'b0;
    if (hit) begin
      if (hit_pos == off_q) begin
        cst_n = CAND_NONE;
      end else if (!noise_immune) begin
        take  = 1'b1;
        cst_n = CAND_NONE;
      end else if (cst_q == CAND_HELD && cand_q == hit_pos) begin
        take  = 1'b1;
        cst_n = CAND_NONE;
      end else begin
        cand_n = hit_pos;
        cst_n  = CAND_HELD;
      end
      if (take) off_n = hit_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      cand_q <= '0;
      cst_q  <= CAND_NONE;
    end else begin
      off_q  <= off_n;
      cand_q <= cand_n;
      cst_q  <= cst_n;
    end
  end

  assign off_use   = bypass ? '0 : off_n;
  assign bound     = off_q;
  assign cand_held = (cst_q == CAND_HELD);
endmodule

// File: rtl/hdv_word_extract.sv
module hdv_word_extract #(
  parameter int BUS_W = 20,
  parameter int OFF_W = 5
) (
  input  logic [2*BUS_W-2:0] seg,
  input  logic [OFF_W-1:0]   off,
  output logic [BUS_W-1:0]   word
);
  logic [2*BUS_W-2:0] shifted;

  always_comb begin
    shifted = seg >> off;
    word    = shifted[BUS_W-1:0];
  end
endmodule

// File: rtl/hdv_descram_framer.sv
module hdv_descram_framer
  import hdv_pkg::*;
#(
  parameter int SYM_W_P  = hdv_pkg::SYM_W,
  parameter int LANES_P  = hdv_pkg::LANES,
  parameter int TAP_LO_P = hdv_pkg::SCR_TAP_LO,
  parameter int TAP_HI_P = hdv_pkg::SCR_TAP_HI
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SYM_W_P*LANES_P-1:0] data_in,
  input  logic                       skip_descramble,
  input  logic                       skip_framing,
  input  logic                       noise_immune,
  output logic [SYM_W_P*LANES_P-1:0] word_out
);
  localparam int BUS_W     = SYM_W_P * LANES_P;
  localparam int OFF_W     = $clog2(BUS_W);
  localparam int WIN_WORDS = PRE_ONES_WORDS + PRE_ZERO_WORDS + 1;
  localparam int WIN_W     = WIN_WORDS * BUS_W;

  // reset: asynchronous assertion, synchronised release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [BUS_W-1:0] descr_word;

  hdv_bit_descrambler #(
    .BUS_W (BUS_W),
    .TAP_LO(TAP_LO_P),
    .TAP_HI(TAP_HI_P)
  ) u_descr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .bypass(skip_descramble),
    .din   (data_in),
    .dout  (descr_word)
  );

  // decoded-word history forming the search window
  logic [WIN_WORDS-1:1][BUS_W-1:0] hold_q, hold_n;

  always_comb begin
    hold_n[1] = descr_word;
    for (int i = 2; i < WIN_WORDS; i++) hold_n[i] = hold_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_q <= '0;
    else             hold_q <= hold_n;
  end

  logic [WIN_W-1:0] win_flat;
  for (genvar g = 0; g < WIN_WORDS; g++) begin : g_win
    if (g == WIN_WORDS - 1) begin : g_new
      assign win_flat[g*BUS_W +: BUS_W] = descr_word;
    end else begin : g_old
      assign win_flat[g*BUS_W +: BUS_W] = hold_q[WIN_WORDS-1-g];
    end
  end

  logic [BUS_W-1:0] oldest;
  assign oldest = hold_q[WIN_WORDS-1];

  logic             hit;
  logic [OFF_W-1:0] hit_pos;

  hdv_preamble_finder #(
    .BUS_W (BUS_W),
    .ONES_W(PRE_ONES_WORDS * BUS_W),
    .ZERO_W(PRE_ZERO_WORDS * BUS_W),
    .WIN_W (WIN_W),
    .OFF_W (OFF_W)
  ) u_find (
    .window (win_flat),
    .hit    (hit),
    .hit_pos(hit_pos)
  );

  logic [OFF_W-1:0] off_use;
  logic [OFF_W-1:0] bound_q;
  logic             cand_held;

  hdv_boundary_ctrl #(
    .OFF_W(OFF_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit         (hit),
    .hit_pos     (hit_pos),
    .noise_immune(noise_immune),
    .bypass      (skip_framing),
    .off_use     (off_use),
    .bound       (bound_q),
    .cand_held   (cand_held)
  );

  logic [BUS_W-1:0] aligned;

  hdv_word_extract #(
    .BUS_W(BUS_W),
    .OFF_W(OFF_W)
  ) u_ext (
    .seg (win_flat[2*BUS_W-2:0]),
    .off (off_use),
    .word(aligned)
  );

  logic [BUS_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) word_q <= '0;
    else             word_q <= aligned;
  end

  assign word_out = word_q;
endmodule

// File: rtl/hdv_descram_framer_chk.sv
module hdv_descram_framer_chk #(
  parameter int BUS_W = 20,
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [BUS_W-1:0] data_in,
  input logic             skip_descramble,
  input logic             skip_framing,
  input logic             noise_immune,
  input logic [BUS_W-1:0] descr_word,
  input logic [BUS_W-1:0] oldest,
  input logic             hit,
  input logic [OFF_W-1:0] hit_pos,
  input logic [OFF_W-1:0] bound_q,
  input logic             cand_held,
  input logic [BUS_W-1:0] word_out
);
  // R3
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip_descramble |=> descr_word == $past(data_in));

  // R4
  frame_skip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip_framing |=> word_out == $past(oldest));

  // R7
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> $stable(bound_q));

  // R6
  bound_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && !noise_immune) |=> bound_q == $past(hit_pos));

  // R8
  first_sight_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && noise_immune && !cand_held && hit_pos != bound_q) |=> $stable(bound_q));
endmodule

bind hdv_descram_framer hdv_descram_framer_chk #(
  .BUS_W(BUS_W),
  .OFF_W(OFF_W)
) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .data_in        (data_in),
  .skip_descramble(skip_descramble),
  .skip_framing   (skip_framing),
  .noise_immune   (noise_immune),
  .descr_word     (descr_word),
  .oldest         (oldest),
  .hit            (hit),
  .hit_pos        (hit_pos),
  .bound_q        (bound_q),
  .cand_held      (cand_held),
  .word_out       (word_out)
);

// File: tb/sim_hdv_descram_framer.sv
`timescale 1ns/1ps
module sim_hdv_descram_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] data_in;
  logic        skip_descramble, skip_framing, noise_immune;
  logic [19:0] word_out;

  always #2 clk = ~clk;

  hdv_descram_framer u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_in        (data_in),
    .skip_descramble(skip_descramble),
    .skip_framing   (skip_framing),
    .noise_immune   (noise_immune),
    .word_out       (word_out)
  );

  typedef struct {
    int          due;
    logic [19:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  int    edge_cnt = 0;
  bit    strm [0:4095];
  int    eoff [0:255];
  string etag [0:255];
  int    wp;
  logic [8:0]  sh;
  logic        nprev;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: word_out=%h expected %h", tag, act, exp);
    end
  endtask

  function automatic void put_word(logic [19:0] w);
    for (int i = 0; i < 20; i++) begin strm[wp] = w[i]; wp++; end
  endfunction

  function automatic void put_junk(int n);
    for (int i = 0; i < n; i++) begin strm[wp] = (i % 2) != 0; wp++; end
  endfunction

  function automatic logic [9:0] vid();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return 10'(64 + (int'(lfsr) % 896));
  endfunction

  function automatic void put_data(int n);
    for (int i = 0; i < n; i++) begin
      logic [9:0] c, y;
      c = vid();
      y = vid();
      put_word({y, c});
    end
  endfunction

  function automatic int put_trs();
    int p;
    p = wp;
    put_word(20'hFFFFF);
    put_word(20'h00000);
    put_word(20'h00000);
    put_word({10'h274, 10'h2D8});
    return p;
  endfunction

  function automatic void mark(int a, int b, int off, string tag);
    for (int t = a; t <= b; t++) begin eoff[t] = off; etag[t] = tag; end
  endfunction

  function automatic logic [19:0] enc(int t);
    logic [19:0] w;
    for (int i = 0; i < 20; i++) begin
      logic d, s;
      d = strm[20*t+i];
      if (skip_descramble) w[i] = d;
      else begin
        s     = d ^ sh[3] ^ sh[8];
        sh    = {sh[7:0], s};
        nprev = nprev ^ s;
        w[i]  = nprev;
      end
    end
    return w;
  endfunction

  task automatic start_phase(logic bd, logic bf, logic ni);
    @(negedge clk);
    rst_n = 1'b0;
    data_in = '0;
    skip_descramble = bd;
    skip_framing = bf;
    noise_immune = ni;
    for (int i = 0; i < 4096; i++) strm[i] = 1'b0;
    for (int i = 0; i < 256; i++) begin eoff[i] = -1; etag[i] = ""; end
    wp = 0; sh = '0; nprev = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", word_out, 20'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive();
    int n;
    n = wp / 20 + 6;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      data_in = enc(t);
      if (t < 256 && eoff[t] >= 0) begin
        item_t it;
        for (int b = 0; b < 20; b++) it.exp[b] = strm[20*t + eoff[t] + b];
        it.due = edge_cnt + 5;
        it.tag = etag[t];
        q.push_back(it);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  // monitor: pop expected items when their output cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == edge_cnt) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, word_out, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pa, pb, pj, p0, p1, p2, p3, last;
    rst_n = 1'b0;
    data_in = '0;
    skip_descramble = 1'b0;
    skip_framing = 1'b0;
    noise_immune = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", word_out, 20'h0);

    // normal mode: lock, slip without preamble, relock
    start_phase(1'b0, 1'b0, 1'b0);
    put_junk(7); put_data(5);
    pa = put_trs(); put_data(10);
    pj = wp; put_junk(5); put_data(8);
    pb = put_trs(); put_data(10);
    last = wp / 20 - 2;
    mark(pa / 20, pj / 20 - 1, pa % 20, "R2");
    etag[pa / 20] = "R5";
    etag[pa / 20 + 3] = "R11";
    mark(pj / 20, pb / 20 - 1, pa % 20, "R7");
    mark(pb / 20, last, pb % 20, "R6");
    drive();

    // descrambler bypassed, framer active
    start_phase(1'b1, 1'b0, 1'b0);
    put_junk(3); put_data(4);
    pa = put_trs(); put_data(8);
    mark(pa / 20, wp / 20 - 2, pa % 20, "R3");
    drive();

    // framer bypassed, descrambler active
    start_phase(1'b0, 1'b1, 1'b0);
    put_junk(9); put_data(4);
    pa = put_trs(); put_data(6);
    mark(0, wp / 20 - 2, 0, "R4");
    drive();

    // noise-immune sequence
    start_phase(1'b0, 1'b0, 1'b1);
    put_data(3);
    p0 = put_trs(); put_data(4);
    put_junk(6); put_data(3);
    p1 = put_trs(); put_data(4);
    put_junk(14); put_data(3);
    p2 = put_trs(); put_data(3);
    put_junk(6); put_data(3);
    pb = put_trs(); put_data(4);
    p3 = put_trs(); put_data(5);
    mark(p0 / 20, p2 / 20 - 1, 0, "R8");
    mark(p2 / 20, p3 / 20 - 1, 0, "R10");
    mark(p3 / 20, wp / 20 - 2, p3 % 20, "R9");
    drive();

    // both bypasses together
    start_phase(1'b1, 1'b1, 1'b0);
    put_junk(5); put_data(3);
    pa = put_trs(); put_data(3);
    mark(0, wp / 20 - 2, 0, "R4");
    drive();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule